// File: doc/BRIEF.md
# Shared-Line Interrupt Aggregator

The block collects two event pulses, one announcing that a conversion has finished and one announcing that a vector transformation has finished, and turns them into a single active-low interrupt request. Each source is allowed through by its own enable bit in a control word. An event that gets through is recorded in a status word. Reading that word reports which source fired and clears the record. The output never drives the line high. It only asks for the line to be pulled low, so several devices can share one wired interrupt net that has an external pull-up.

A control bit sets how the request behaves. In pulse mode the line is pulled low for one clock per accepted event. In level mode the line stays low until the host reads the status word. Level mode is the one to use when the line is shared, because the host can then poll every device on the net and find out which ones are asking. The host bus is reduced to a one-bit register select, a write strobe and a read strobe, with returned data registered.

Top module: `irq_hub`

## Requirements
- R1: After reset both enables are 0, the mode is pulse mode, the status word is 0 and `irq_pull_low` is 0.
- R2: A write with `bus_sel`=0 loads the control word from bit 7 (conversion enable), bit 6 (transformation enable) and bit 8 (1 = level mode). A control read returns these three bits in the same positions, with all other bits 0.
- R3: A `conv_done` pulse while bit 7 is set sets status bit 0 and status bit 11.
- R4: An `xform_done` pulse while bit 6 is set sets status bit 1 and status bit 11.
- R5: A pulse on a disabled source changes no status bit and leaves `irq_pull_low` at 0.
- R6: A read strobe with `bus_sel`=1 places the status word on `bus_rdata` in the following cycle and clears bits 11, 1 and 0.
- R7: In pulse mode `irq_pull_low` is 1 for exactly the one cycle after the clock edge that accepts an enabled event.
- R8: In level mode `irq_pull_low` rises after an accepted event and stays 1 until the edge that performs a status read.
- R9: An enabled event in the same cycle as a status read is not lost. The read returns the flags as they were before the event, and the event's flags, and in level mode the line, are set again right after the clear.
- R10: Enabled events from both sources in one cycle set bits 0, 1 and 11 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register select: 0 = control word, 1 = status word |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 12 | Write data |
| bus_rdata | output | 12 | Read data, valid the cycle after the read strobe |
| conv_done | input | 1 | End-of-conversion event pulse |
| xform_done | input | 1 | End-of-transformation event pulse |
| irq_pull_low | output | 1 | 1 = pull the shared interrupt line low, 0 = release it |

## Verification
Two functions can land on the same clock edge: the clear that a status read performs and the set that an accepted event performs. The bench drives an event pulse together with the read strobe. It then expects the pre-event word from that read and the event's flags from the next read. In level mode it also expects the line to stay pulled low across the read. The same collision is repeated in pulse mode, where the line must give exactly one pulse.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int unsigned DATA_W      = 12;
  localparam int unsigned CTL_LEVEL   = 8;
  localparam int unsigned CTL_CONV_EN = 7;
  localparam int unsigned CTL_XF_EN   = 6;
  localparam int unsigned ST_PEND     = 11;
  localparam int unsigned ST_XF       = 1;
  localparam int unsigned ST_CONV     = 0;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_STAT = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic level;
    logic conv_en;
    logic xf_en;
  } ctl_t;

  typedef struct packed {
    logic pend;
    logic xf;
    logic conv;
  } flags_t;
endpackage

// File: rtl/irq_hub_ctrl.sv
module irq_hub_ctrl
  import irq_hub_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctl,
  input  logic [DW-1:0] wdata,
  output ctl_t          ctl
);
  ctl_t ctl_d;
  logic unused_wbits;

  assign unused_wbits = ^wdata;

  always_comb begin
    ctl_d = ctl;
    if (wr_ctl) begin
      ctl_d.level   = wdata[CTL_LEVEL];
      ctl_d.conv_en = wdata[CTL_CONV_EN];
      ctl_d.xf_en   = wdata[CTL_XF_EN];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl <= '0;
    else        ctl <= ctl_d;
  end

  // R2: a control write is taken at the next edge
  a_r2_ctl_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> (ctl.level == $past(wdata[CTL_LEVEL]))
            && (ctl.conv_en == $past(wdata[CTL_CONV_EN]))
            && (ctl.xf_en == $past(wdata[CTL_XF_EN])));
  a_r2_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctl |=> $stable(ctl));
endmodule

// File: rtl/irq_hub_status.sv
module irq_hub_status
  import irq_hub_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  ctl_t   ctl,
  input  logic   conv_evt,
  input  logic   xf_evt,
  input  logic   rd_stat,
  output flags_t flags,
  output logic   fire
);
  logic   fire_conv, fire_xf;
  flags_t base, flags_d;

  assign fire_conv = conv_evt & ctl.conv_en;
  assign fire_xf   = xf_evt & ctl.xf_en;
  assign fire      = fire_conv | fire_xf;

  always_comb begin
    base         = rd_stat ? '0 : flags;
    flags_d.conv = base.conv | fire_conv;
    flags_d.xf   = base.xf | fire_xf;
    flags_d.pend = base.pend | fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_d;
  end

  a_r3_conv_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_evt && ctl.conv_en) |=> (flags.conv && flags.pend));
  a_r4_xf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (xf_evt && ctl.xf_en) |=> (flags.xf && flags.pend));
  a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!(conv_evt && ctl.conv_en) && !(xf_evt && ctl.xf_en) && !rd_stat) |=> $stable(flags));
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !conv_evt && !xf_evt) |=> (flags == '0));
  a_r9_collide_conv: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && conv_evt && ctl.conv_en) |=> (flags.conv && flags.pend));
endmodule

// File: rtl/irq_hub_rdport.sv
module irq_hub_rdport
  import irq_hub_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  reg_sel_e      sel,
  input  ctl_t          ctl,
  input  flags_t        flags,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] word, rdata_d;

  always_comb begin
    word = '0;
    if (sel == SEL_STAT) begin
      word[ST_PEND] = flags.pend;
      word[ST_XF]   = flags.xf;
      word[ST_CONV] = flags.conv;
    end else begin
      word[CTL_LEVEL]   = ctl.level;
      word[CTL_CONV_EN] = ctl.conv_en;
      word[CTL_XF_EN]   = ctl.xf_en;
    end
    rdata_d = rd_en ? word : rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rdata_d;
  end

  a_r6_status_returned: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == SEL_STAT) |=> (rdata[ST_PEND] == $past(flags.pend))
      && (rdata[ST_XF] == $past(flags.xf)) && (rdata[ST_CONV] == $past(flags.conv)));
endmodule

// File: rtl/irq_hub_line.sv
module irq_hub_line (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic level,
  input  logic pend,
  output logic pull
);
  logic pulse_q, pulse_d;

  assign pulse_d = fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  assign pull = level ? pend : pulse_q;
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          conv_done,
  input  logic          xform_done,
  output logic          irq_pull_low
);
  reg_sel_e sel;
  ctl_t     ctl;
  flags_t   flags;
  logic     wr_ctl, rd_stat, fire;

  assign sel     = reg_sel_e'(bus_sel);
  assign wr_ctl  = bus_wr && (sel == SEL_CTRL);
  assign rd_stat = bus_rd && (sel == SEL_STAT);

  irq_hub_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .wdata(bus_wdata), .ctl(ctl)
  );

  irq_hub_status u_status (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .conv_evt(conv_done),
    .xf_evt(xform_done), .rd_stat(rd_stat), .flags(flags), .fire(fire)
  );

  irq_hub_rdport #(.DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(bus_rd), .sel(sel), .ctl(ctl),
    .flags(flags), .rdata(bus_rdata)
  );

  irq_hub_line u_line (
    .clk(clk), .rst_n(rst_n), .fire(fire), .level(ctl.level),
    .pend(flags.pend), .pull(irq_pull_low)
  );

  // R7: pulse mode releases the line unless an event was just accepted
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.level && !fire && !wr_ctl) |=> !irq_pull_low);
  a_r7_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !wr_ctl) |=> irq_pull_low);
  // R8: level mode holds the line until the status read
  a_r8_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.level && irq_pull_low && !rd_stat && !wr_ctl) |=> irq_pull_low);
  a_r8_level_release: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.level && rd_stat && !fire && !wr_ctl) |=> !irq_pull_low);
endmodule

// File: tb/tb_irq_hub.sv
module tb_irq_hub;
  localparam int CLK_P = 10;

  logic        clk, rst_n, bus_sel, bus_wr, bus_rd, conv_done, xform_done;
  logic [11:0] bus_wdata, bus_rdata;
  logic        irq_pull_low;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [11:0] exp_q[$];
  string       tag_q[$];

  irq_hub dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_done(conv_done),
    .xform_done(xform_done), .irq_pull_low(irq_pull_low)
  );

  initial clk = 0;
  always #(CLK_P/2) clk = ~clk;

  task automatic check(string req, logic [11:0] act, logic [11:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %03h expected %03h", req, act, exp);
    end
  endtask

  // monitor: compare read data the cycle after each read strobe
  always @(posedge clk) begin
    if (rst_n && bus_rd) begin
      @(negedge clk);
      if (exp_q.size() == 0) check("scoreboard-empty", 12'h0, 12'h1);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic wr_ctl(logic [11:0] v);
    bus_sel = 0; bus_wr = 1; bus_wdata = v;
    @(negedge clk);
    bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic rd(logic s, logic [11:0] exp, string req, logic c = 0, logic x = 0);
    exp_q.push_back(exp); tag_q.push_back(req);
    bus_sel = s; bus_rd = 1; conv_done = c; xform_done = x;
    @(negedge clk);
    bus_rd = 0; conv_done = 0; xform_done = 0;
  endtask

  task automatic evt(logic c, logic x);
    conv_done = c; xform_done = x;
    @(negedge clk);
    conv_done = 0; xform_done = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P*20000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got 000 expected 001");
    finish_run();
  end

  initial begin
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    conv_done = 0; xform_done = 0;
    repeat (3) @(negedge clk);
    check("R1 line after reset", {11'b0, irq_pull_low}, 12'h0);
    rst_n = 1;
    @(negedge clk);
    rd(0, 12'h000, "R1 control after reset");
    rd(1, 12'h000, "R1 status after reset");

    // R5: disabled sources
    evt(1, 1);
    check("R5 line with sources disabled", {11'b0, irq_pull_low}, 12'h0);
    rd(1, 12'h000, "R5 status after disabled events");

    // R2: control write and readback
    wr_ctl(12'h080);
    rd(0, 12'h080, "R2 conversion enable readback");
    wr_ctl(12'hFFF);
    rd(0, 12'h1C0, "R2 only mode/enable bits stored");
    wr_ctl(12'h080);

    // R7 / R3: pulse mode, conversion enabled
    evt(1, 0);
    check("R7 pulse present", {11'b0, irq_pull_low}, 12'h1);
    @(negedge clk);
    check("R7 pulse one cycle", {11'b0, irq_pull_low}, 12'h0);
    evt(0, 1);
    check("R5 disabled transform no pulse", {11'b0, irq_pull_low}, 12'h0);
    rd(1, 12'h801, "R3 conversion flags");
    rd(1, 12'h000, "R6 status cleared by read");

    // R10 / R4
    wr_ctl(12'h0C0);
    evt(1, 1);
    rd(1, 12'h803, "R10 both sources");
    evt(0, 1);
    rd(1, 12'h802, "R4 transformation flags");

    // R8: level mode
    wr_ctl(12'h1C0);
    rd(0, 12'h1C0, "R2 level mode readback");
    evt(0, 1);
    for (int i = 0; i < 3; i++) begin
      check("R8 line held", {11'b0, irq_pull_low}, 12'h1);
      @(negedge clk);
    end
    rd(1, 12'h802, "R8 status in level mode");
    check("R8 line released after read", {11'b0, irq_pull_low}, 12'h0);

    // R9: event colliding with status read, level mode
    evt(0, 1);
    rd(1, 12'h802, "R9 read returns pre-event flags", 1, 0);
    check("R9 line stays low across read", {11'b0, irq_pull_low}, 12'h1);
    rd(1, 12'h801, "R9 colliding event kept");
    check("R9 line released", {11'b0, irq_pull_low}, 12'h0);

    // R9 in pulse mode
    wr_ctl(12'h0C0);
    rd(1, 12'h000, "R9 pulse-mode collision read", 0, 1);
    check("R9 pulse on collision", {11'b0, irq_pull_low}, 12'h1);
    @(negedge clk);
    check("R7 collision pulse one cycle", {11'b0, irq_pull_low}, 12'h0);
    rd(1, 12'h802, "R9 pulse-mode event kept");

    // R1: reset mid-run clears everything
    evt(1, 0);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 line after second reset", {11'b0, irq_pull_low}, 12'h0);
    rd(1, 12'h000, "R1 status after second reset");
    rd(0, 12'h000, "R1 control after second reset");
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule